// File: doc/BRIEF.md
# Module Site Access Controller

This block turns a host's single-cycle read or write request into one bus cycle on one of four plug-in module sites. The host address encodes the target space, the site and a byte offset. The block decodes the space into one of three active-low select groups: identification (64 bytes per site), I/O (128 bytes per site) and interrupt. It presents the word address and active-low byte enables on the module bus, and drives a half-rate module clock. It then waits for the addressed site's acknowledge.

An access ends in one of two ways. If the site acknowledges, the block returns the read data. If 32 module-clock cycles pass without an acknowledge, the access ends with a time-out status and all-ones read data. In both cases the host sees a one-cycle ready pulse. Byte and word transfers are both supported. For a byte transfer the lane comes from the lowest offset bit, and the lane not used returns all ones, as undriven module data lines do.

Top module: `ipac_top`

## Requirements
- R1: The host address is {space[1:0], site[1:0], offset[6:0]}, with space 0 = identification, 1 = I/O and 2 = interrupt. During an access exactly one active-low select is asserted: bit `site` of the decoded space's select vector. `modAddr` carries offset[6:1], and both stay stable until the access ends.
- R2: A request to space 3, or to identification offsets 64 and above, asserts no select. It completes with ready in the first cycle after it is accepted, read data 16'hFFFF and no time-out.
- R3: The byte enables `modBsN` are active low, with bit 0 for data[7:0] and bit 1 for data[15:8]. A word access drives 2'b00. A byte access at an even offset drives 2'b10, and at an odd offset drives 2'b01.
- R4: A word read returns `modDin`. A byte read returns the enabled lane in its own position and 8'hFF in the other lane.
- R5: During a write, `modRwN` is low, `modDoe` is high and `modDout` equals the host write data. Reads keep `modRwN` high and `modDoe` low. Writes return 16'hFFFF as read data.
- R6: `modClk` toggles on every clock edge, so it runs at half the clock rate.
- R7: An access completes only on the addressed site's acknowledge (`modAckN` low). Acknowledges from other sites are ignored.
- R8: If no acknowledge arrives within 32 module-clock cycles, the access ends with `hostTimeout` set and read data 16'hFFFF. An acknowledge that arrives earlier completes normally.
- R9: `hostReady` is high for exactly one cycle per access, and all selects are deasserted while it is high.
- R10: `hostTimeout` keeps its value from the ready pulse until the next accepted request, which clears it.
- R11: A request that arrives while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock (twice the module clock) |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Single-cycle request strobe |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostWord | input | 1 | 1 = 16-bit transfer, 0 = byte |
| hostAddr | input | 11 | {space, site, offset} |
| hostWdata | input | 16 | Write data |
| hostRdata | output | 16 | Read data, valid with ready |
| hostReady | output | 1 | One-cycle completion pulse |
| hostTimeout | output | 1 | Last access ended without acknowledge |
| modClk | output | 1 | Half-rate module clock |
| modIdSelN | output | 4 | Identification-space selects, one per site |
| modIoSelN | output | 4 | I/O-space selects, one per site |
| modIntSelN | output | 4 | Interrupt-space selects, one per site |
| modAddr | output | 6 | Word address (offset[6:1]) |
| modBsN | output | 2 | Active-low byte enables |
| modRwN | output | 1 | High = read, low = write |
| modDout | output | 16 | Write data to modules |
| modDoe | output | 1 | Write data output enable |
| modDin | input | 16 | Read data from modules (undriven bits high) |
| modAckN | input | 4 | Active-low acknowledge, one per site |

## Verification
The bench builds the block with its defaults: four sites, a 128-byte offset field, a 64-byte identification space and a 32-cycle time-out. These values make every site and space code reachable, including the identification range bound at offset 64 and the reserved space code. The 32-cycle limit lets a full time-out complete in about 66 clocks, so several time-outs fit in one short run. The same limit leaves room for a late acknowledge at about 20 module cycles, which must still complete without a time-out.

// File: rtl/ipac_pkg.sv
package ipac_pkg;

  typedef enum logic [1:0] {
    SP_ID  = 2'd0,
    SP_IO  = 2'd1,
    SP_INT = 2'd2,
    SP_RSV = 2'd3
  } spaceT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new host request
    logic open;     // assert the select of the latched site/space
    logic capture;  // acknowledge seen: latch read data
    logic expire;   // no acknowledge in time
    logic close;    // deassert all selects
  } strobeT;

endpackage

// File: rtl/ipac_ctrl.sv
module ipac_ctrl
  import ipac_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   hostReq,
  input  logic   reqBad,
  input  logic   ackHit,
  output strobeT strobe,
  output logic   hostReady,
  output logic   modClk
);

  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } stateT;

  stateT          state, stateNxt;
  logic [TO_W-1:0] waitCnt, waitCntNxt;
  logic            modClkQ;
  logic            clkEn;

  // module clock: half rate, bus events on its rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modClkQ <= 1'b0;
    else       modClkQ <= ~modClkQ;
  end

  assign clkEn  = ~modClkQ;
  assign modClk = modClkQ;

  always_comb begin
    stateNxt   = state;
    waitCntNxt = waitCnt;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        if (hostReq) begin
          strobe.load = 1'b1;
          stateNxt    = reqBad ? ST_DONE : ST_ARM;
        end
      end
      ST_ARM: begin
        if (clkEn) begin
          strobe.open = 1'b1;
          waitCntNxt  = '0;
          stateNxt    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (clkEn) begin
          if (ackHit) begin
            strobe.capture = 1'b1;
            strobe.close   = 1'b1;
            stateNxt       = ST_DONE;
          end else if (waitCnt == TO_W'(TIMEOUT_CYC - 1)) begin
            strobe.expire  = 1'b1;
            strobe.close   = 1'b1;
            stateNxt       = ST_DONE;
          end else begin
            waitCntNxt     = waitCnt + 1'b1;
          end
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNxt;
      waitCnt <= waitCntNxt;
    end
  end

  assign hostReady = (state == ST_DONE);

endmodule

// File: rtl/ipac_dpath.sv
module ipac_dpath
  import ipac_pkg::*;
#(
  parameter int SITES    = 4,
  parameter int IO_BYTES = 128,
  parameter int ID_BYTES = 64,
  parameter int DW       = 16,
  localparam int SITE_W  = $clog2(SITES),
  localparam int OFF_W   = $clog2(IO_BYTES),
  localparam int ADDR_W  = 2 + SITE_W + OFF_W,
  localparam int LANES   = DW / 8,
  localparam int LANE_W  = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrite,
  input  logic                hostWord,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DW-1:0]       hostWdata,
  input  strobeT              strobe,
  output logic                reqBad,
  output logic                ackHit,
  output logic [DW-1:0]       hostRdata,
  output logic                hostTimeout,
  output logic [SITES-1:0]    modIdSelN,
  output logic [SITES-1:0]    modIoSelN,
  output logic [SITES-1:0]    modIntSelN,
  output logic [OFF_W-LANE_W-1:0] modAddr,
  output logic [LANES-1:0]    modBsN,
  output logic                modRwN,
  output logic [DW-1:0]       modDout,
  output logic                modDoe,
  input  logic [DW-1:0]       modDin,
  input  logic [SITES-1:0]    modAckN
);

  spaceT              spaceIn, spaceQ;
  logic [SITE_W-1:0]  siteIn, siteQ;
  logic [OFF_W-1:0]   offIn, offQ;
  logic               writeQ, wordQ, selOn, toQ;
  logic [DW-1:0]      wdataQ, rdataQ, rdLane;
  logic [LANES-1:0]   laneOn;

  // request decode
  assign spaceIn = spaceT'(hostAddr[ADDR_W-1 -: 2]);
  assign siteIn  = hostAddr[OFF_W +: SITE_W];
  assign offIn   = hostAddr[OFF_W-1:0];
  assign reqBad  = (spaceIn == SP_RSV) ||
                   ((spaceIn == SP_ID) && (int'(offIn) >= ID_BYTES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spaceQ <= SP_ID;
      siteQ  <= '0;
      offQ   <= '0;
      writeQ <= 1'b0;
      wordQ  <= 1'b0;
      wdataQ <= '0;
    end else if (strobe.load) begin
      spaceQ <= spaceIn;
      siteQ  <= siteIn;
      offQ   <= offIn;
      writeQ <= hostWrite;
      wordQ  <= hostWord;
      wdataQ <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             selOn <= 1'b0;
    else if (strobe.close) selOn <= 1'b0;
    else if (strobe.open)  selOn <= 1'b1;
  end

  // per-site select decode
  for (genvar s = 0; s < SITES; s++) begin : g_site
    logic hit;
    assign hit           = selOn && (siteQ == SITE_W'(s));
    assign modIdSelN[s]  = ~(hit && (spaceQ == SP_ID));
    assign modIoSelN[s]  = ~(hit && (spaceQ == SP_IO));
    assign modIntSelN[s] = ~(hit && (spaceQ == SP_INT));
  end

  assign ackHit = ~modAckN[siteQ];

  // lane enables and read lane merge
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneOn[l]          = wordQ || (offQ[LANE_W-1:0] == LANE_W'(l));
    assign rdLane[l*8 +: 8]   = laneOn[l] ? modDin[l*8 +: 8] : 8'hFF;
  end

  assign modBsN  = selOn ? ~laneOn : '1;
  assign modAddr = offQ[OFF_W-1:LANE_W];
  assign modRwN  = ~(selOn && writeQ);
  assign modDoe  = selOn && writeQ;
  assign modDout = wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '1;
      toQ    <= 1'b0;
    end else begin
      if (strobe.load) begin
        rdataQ <= '1;
        toQ    <= 1'b0;
      end
      if (strobe.capture && !writeQ) rdataQ <= rdLane;
      if (strobe.expire)             toQ    <= 1'b1;
    end
  end

  assign hostRdata   = rdataQ;
  assign hostTimeout = toQ;

endmodule

// File: rtl/ipac_top.sv
module ipac_top
  import ipac_pkg::*;
#(
  parameter int SITES       = 4,
  parameter int IO_BYTES    = 128,
  parameter int ID_BYTES    = 64,
  parameter int DW          = 16,
  parameter int TIMEOUT_CYC = 32,
  localparam int SITE_W     = $clog2(SITES),
  localparam int OFF_W      = $clog2(IO_BYTES),
  localparam int ADDR_W     = 2 + SITE_W + OFF_W,
  localparam int LANES      = DW / 8,
  localparam int MA_W       = OFF_W - $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostWord,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DW-1:0]     hostWdata,
  output logic [DW-1:0]     hostRdata,
  output logic              hostReady,
  output logic              hostTimeout,
  output logic              modClk,
  output logic [SITES-1:0]  modIdSelN,
  output logic [SITES-1:0]  modIoSelN,
  output logic [SITES-1:0]  modIntSelN,
  output logic [MA_W-1:0]   modAddr,
  output logic [LANES-1:0]  modBsN,
  output logic              modRwN,
  output logic [DW-1:0]     modDout,
  output logic              modDoe,
  input  logic [DW-1:0]     modDin,
  input  logic [SITES-1:0]  modAckN
);

  strobeT strobe;
  logic   reqBad, ackHit;

  ipac_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .reqBad(reqBad),
    .ackHit(ackHit), .strobe(strobe), .hostReady(hostReady), .modClk(modClk)
  );

  ipac_dpath #(
    .SITES(SITES), .IO_BYTES(IO_BYTES), .ID_BYTES(ID_BYTES), .DW(DW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .hostWrite(hostWrite), .hostWord(hostWord),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .strobe(strobe),
    .reqBad(reqBad), .ackHit(ackHit), .hostRdata(hostRdata),
    .hostTimeout(hostTimeout), .modIdSelN(modIdSelN), .modIoSelN(modIoSelN),
    .modIntSelN(modIntSelN), .modAddr(modAddr), .modBsN(modBsN),
    .modRwN(modRwN), .modDout(modDout), .modDoe(modDoe), .modDin(modDin),
    .modAckN(modAckN)
  );

endmodule

// File: rtl/ipac_checker.sv
module ipac_checker #(
  parameter int SITES       = 4,
  parameter int DW          = 16,
  parameter int LANES       = 2,
  parameter int MA_W        = 6,
  parameter int TIMEOUT_CYC = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostReady,
  input logic             hostTimeout,
  input logic [DW-1:0]    hostRdata,
  input logic             modClk,
  input logic [SITES-1:0] modIdSelN,
  input logic [SITES-1:0] modIoSelN,
  input logic [SITES-1:0] modIntSelN,
  input logic [MA_W-1:0]  modAddr,
  input logic [LANES-1:0] modBsN,
  input logic             modRwN,
  input logic             modDoe
);

  logic [3*SITES-1:0] selAct;
  logic               anySel;
  int unsigned        selCnt;

  assign selAct = ~{modIdSelN, modIoSelN, modIntSelN};
  assign anySel = |selAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       selCnt <= 0;
    else if (anySel) selCnt <= selCnt + 1;
    else             selCnt <= 0;
  end

  always_comb begin
    if (rstN) AST_SEL_WINDOW: assert (selCnt <= 2 * TIMEOUT_CYC); // R8
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selAct)); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    anySel && $past(anySel) |-> $stable(modAddr) && $stable(modBsN)); // R1
  AST_LANE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    anySel |-> (modBsN != '1)); // R3
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    modDoe |-> anySel && !modRwN); // R5
  AST_MODCLK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !modClk |=> modClk); // R6
  AST_MODCLK_FALL: assert property (@(posedge clk) disable iff (!rstN)
    modClk |=> !modClk); // R6
  AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    hostReady && hostTimeout |-> hostRdata == '1); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady); // R9
  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> !anySel); // R9

endmodule

bind ipac_top ipac_checker #(
  .SITES(SITES), .DW(DW), .LANES(LANES), .MA_W(MA_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_checker (
  .clk(clk), .rstN(rstN), .hostReady(hostReady), .hostTimeout(hostTimeout),
  .hostRdata(hostRdata), .modClk(modClk), .modIdSelN(modIdSelN),
  .modIoSelN(modIoSelN), .modIntSelN(modIntSelN), .modAddr(modAddr),
  .modBsN(modBsN), .modRwN(modRwN), .modDoe(modDoe)
);

// File: tb/tb_ipac_top.sv
module tb_ipac_top;

  localparam int TO = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWrite = 1'b0, hostWord = 1'b0;
  logic [10:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostReady, hostTimeout, modClk;
  logic [3:0]  modIdSelN, modIoSelN, modIntSelN;
  logic [5:0]  modAddr;
  logic [1:0]  modBsN;
  logic        modRwN, modDoe;
  logic [15:0] modDout;
  logic [15:0] modDin;
  logic [3:0]  modAckN;

  int checks = 0, fails = 0;

  // module-side model
  logic        respEn = 1'b0;
  int          respSite = 0;
  int          respDelay = 0;
  logic [15:0] respData = '0;
  int          selCnt = 0;
  int          selEver = 0;
  logic [3:0]  obsId, obsIo, obsInt;
  logic [5:0]  obsAddr;
  logic [1:0]  obsBs;
  logic        obsRw, obsDoe;
  logic [15:0] obsDout;
  logic        anySel;

  assign anySel = ~(&{modIdSelN, modIoSelN, modIntSelN});
  assign modDin = respData;

  always_comb begin
    modAckN = '1;
    if (respEn && anySel && selCnt >= respDelay) modAckN[respSite] = 1'b0;
  end

  always @(posedge clk) begin
    if (anySel) begin
      selCnt  <= selCnt + 1;
      selEver <= selEver + 1;
      obsId   <= modIdSelN;  obsIo  <= modIoSelN; obsInt <= modIntSelN;
      obsAddr <= modAddr;    obsBs  <= modBsN;    obsRw  <= modRwN;
      obsDoe  <= modDoe;     obsDout <= modDout;
    end else begin
      selCnt <= 0;
    end
  end

  always #10 clk = ~clk;

  ipac_top dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostWord(hostWord), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostReady(hostReady), .hostTimeout(hostTimeout),
    .modClk(modClk), .modIdSelN(modIdSelN), .modIoSelN(modIoSelN),
    .modIntSelN(modIntSelN), .modAddr(modAddr), .modBsN(modBsN),
    .modRwN(modRwN), .modDout(modDout), .modDoe(modDoe), .modDin(modDin),
    .modAckN(modAckN)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mkAddr(input int sp, input int site, input int off);
    return {sp[1:0], site[1:0], off[6:0]};
  endfunction

  logic [15:0] gotData;
  logic        gotTo;
  int          gotCyc;

  // one access; ready width and bus idle at ready are checked every time
  task automatic access(input logic wr, input logic word, input logic [10:0] a,
                        input logic [15:0] wd);
    @(negedge clk);
    selEver = 0;
    hostReq = 1'b1; hostWrite = wr; hostWord = word; hostAddr = a; hostWdata = wd;
    @(negedge clk);
    hostReq = 1'b0;
    gotCyc = 1;
    while (!hostReady && gotCyc < 300) begin
      @(negedge clk);
      gotCyc++;
    end
    gotData = hostRdata;
    gotTo   = hostTimeout;
    chk(hostReady, "R9 ready seen", 32'(hostReady), 1);
    chk(!anySel, "R9 bus idle at ready", 32'(anySel), 0);
    @(negedge clk);
    chk(!hostReady, "R9 ready one cycle", 32'(hostReady), 0);
  endtask

  task automatic t_reset;
    chk(!hostReady && !hostTimeout, "R9 reset ready/timeout low",
        32'({hostReady, hostTimeout}), 0);
    chk(&{modIdSelN, modIoSelN, modIntSelN} && !modDoe && modRwN,
        "R1 reset bus idle", 32'({modIdSelN, modIoSelN, modIntSelN}), 32'hFFF);
  endtask

  task automatic t_idWord;
    respEn = 1; respSite = 2; respDelay = 0; respData = 16'hA55A;
    access(0, 1, mkAddr(0, 2, 8'h10), '0);
    chk(gotData == 16'hA55A, "R4 word read", 32'(gotData), 32'hA55A);
    chk(obsId == 4'b1011 && obsIo == 4'hF && obsInt == 4'hF, "R1 id select site2",
        32'({obsId, obsIo, obsInt}), 32'hBFF);
    chk(obsAddr == 6'h08, "R1 word address", 32'(obsAddr), 32'h08);
    chk(obsBs == 2'b00, "R3 word enables", 32'(obsBs), 0);
    chk(obsRw && !obsDoe, "R5 read drive", 32'({obsRw, obsDoe}), 2);
    chk(!gotTo, "R8 no timeout on ack", 32'(gotTo), 0);
  endtask

  task automatic t_bytes;
    respEn = 1; respSite = 1; respDelay = 0; respData = 16'h1234;
    access(0, 0, mkAddr(1, 1, 8'h23), '0);
    chk(gotData == 16'h12FF, "R4 odd byte read", 32'(gotData), 32'h12FF);
    chk(obsBs == 2'b01, "R3 odd byte enables", 32'(obsBs), 1);
    chk(obsIo == 4'b1101 && obsId == 4'hF, "R1 io select site1", 32'(obsIo), 32'hD);
    chk(obsAddr == 6'h11, "R1 byte address", 32'(obsAddr), 32'h11);
    respSite = 3;
    access(0, 0, mkAddr(1, 3, 8'h40), '0);
    chk(gotData == 16'hFF34, "R4 even byte read", 32'(gotData), 32'hFF34);
    chk(obsBs == 2'b10, "R3 even byte enables", 32'(obsBs), 2);
  endtask

  task automatic t_int;
    respEn = 1; respSite = 0; respDelay = 0; respData = 16'h00C3;
    access(0, 1, mkAddr(2, 0, 2), '0);
    chk(obsInt == 4'b1110 && obsIo == 4'hF, "R1 int select site0", 32'(obsInt), 32'hE);
    chk(obsAddr == 6'h01, "R1 int request line", 32'(obsAddr), 1);
    chk(gotData == 16'h00C3, "R4 int word read", 32'(gotData), 32'hC3);
  endtask

  task automatic t_write;
    respEn = 1; respSite = 3; respDelay = 0; respData = 16'h0000;
    access(1, 1, mkAddr(1, 3, 8'h7E), 16'hBEEF);
    chk(!obsRw && obsDoe, "R5 write drive", 32'({obsRw, obsDoe}), 1);
    chk(obsDout == 16'hBEEF, "R5 write data", 32'(obsDout), 32'hBEEF);
    chk(gotData == 16'hFFFF, "R5 write rdata ones", 32'(gotData), 32'hFFFF);
  endtask

  task automatic t_timeout;
    respEn = 0; respData = 16'h1111;
    access(0, 1, mkAddr(1, 1, 4), '0);
    chk(gotTo, "R8 timeout flagged", 32'(gotTo), 1);
    chk(gotData == 16'hFFFF, "R8 timeout rdata ones", 32'(gotData), 32'hFFFF);
    chk(gotCyc >= 2 * TO + 1 && gotCyc <= 2 * TO + 2, "R8 timeout latency",
        32'(gotCyc), 2 * TO + 1);
    repeat (5) @(negedge clk);
    chk(hostTimeout, "R10 timeout held", 32'(hostTimeout), 1);
    respEn = 1; respSite = 0; respDelay = 0; respData = 16'h5A5A;
    access(0, 1, mkAddr(1, 0, 0), '0);
    chk(!gotTo && gotData == 16'h5A5A, "R10 cleared by next access",
        32'({gotTo, gotData}), 32'h5A5A);
  endtask

  task automatic t_wrongAck;
    respEn = 1; respSite = 2; respDelay = 0; respData = 16'h7777;
    access(0, 1, mkAddr(1, 0, 6), '0);
    chk(gotTo && gotData == 16'hFFFF, "R7 other site ack ignored",
        32'({gotTo, gotData}), 32'h1FFFF);
  endtask

  task automatic t_slowAck;
    respEn = 1; respSite = 1; respDelay = 40; respData = 16'hC0DE;
    access(0, 1, mkAddr(0, 1, 0), '0);
    chk(!gotTo && gotData == 16'hC0DE, "R8 late ack within limit",
        32'({gotTo, gotData}), 32'hC0DE);
  endtask

  task automatic t_bad;
    respEn = 1; respSite = 0; respDelay = 0; respData = 16'h0101;
    access(0, 1, mkAddr(0, 0, 8'h50), '0);
    chk(gotCyc == 1, "R2 id out of range fast ready", 32'(gotCyc), 1);
    chk(selEver == 0 && gotData == 16'hFFFF && !gotTo, "R2 id out of range no select",
        32'(selEver), 0);
    access(0, 1, mkAddr(3, 1, 0), '0);
    chk(gotCyc == 1 && selEver == 0 && gotData == 16'hFFFF, "R2 reserved space",
        32'(selEver), 0);
  endtask

  task automatic t_busy;
    respEn = 1; respSite = 0; respDelay = 20; respData = 16'h2468;
    @(negedge clk);
    hostReq = 1; hostWrite = 0; hostWord = 1; hostAddr = mkAddr(1, 0, 2);
    @(negedge clk);
    hostReq = 0;
    repeat (6) @(negedge clk);
    hostReq = 1; hostAddr = mkAddr(0, 3, 4);
    @(negedge clk);
    hostReq = 0;
    while (!hostReady) @(negedge clk);
    chk(obsIo == 4'b1110 && obsId == 4'hF, "R11 first access kept", 32'(obsIo), 32'hE);
    selEver = 0;
    repeat (20) @(negedge clk);
    chk(selEver == 0 && !hostReady, "R11 busy request dropped", 32'(selEver), 0);
  endtask

  task automatic t_clock;
    logic prev;
    prev = modClk;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(modClk != prev, "R6 module clock toggles", 32'(modClk), 32'(!prev));
      prev = modClk;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clock();
    t_idWord();
    t_bytes();
    t_int();
    t_write();
    t_timeout();
    t_wrongAck();
    t_slowAck();
    t_bad();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule